// File: doc/BRIEF.md
# Strobe-Driven Flash Address Walker

This block produces the address for a parallel flash part that is read by a small controller with no external bus of its own. The controller drives general-purpose port lines. An 8-bit data bus, a write strobe and a two-bit segment select let it set a 19-bit start address in byte-sized pieces. A separate read strobe marks each byte it fetches from the flash. When that strobe is released, the address steps forward by one, so the next character of a text string is already on the address lines for the following read.

The count drives the flash address pins directly from a register. A registered read-back path returns one byte of the count, chosen by its own select lines. The controller can therefore see where a string walk has reached. All strobes are sampled by the block clock, and actions are taken on their edges, so a strobe held at a level for many cycles acts once.

Top module: `flash_addr_walker`

## Requirements
- R1: A synchronous active-high reset clears the count, the flash address and the read-back byte to 0.
- R2: `flash_addr` is the registered count; it changes only at a clock edge at which a load or an increment takes effect, and otherwise holds.
- R3: On the first clock edge at which `wr_stb` is seen high after being low, with `seg_sel` = 2'b00, count bits [7:0] take `bus_data`; all other bits keep their value.
- R4: On a write-strobe rising edge with `seg_sel` = 2'b01, count bits [15:8] take `bus_data`; all other bits keep their value.
- R5: On a write-strobe rising edge with `seg_sel` = 2'b10, count bits [18:16] take `bus_data[2:0]`; `bus_data[7:3]` is ignored and bits [15:0] keep their value.
- R6: A write-strobe rising edge with `seg_sel` = 2'b11 leaves the count unchanged.
- R7: On the first clock edge at which `rd_stb` is seen low after being high, the count increases by one; while `rd_stb` stays high the address does not move.
- R8: Incrementing from 0x7FFFF gives 0, with no other indication.
- R9: When a write-strobe rising edge and a read-strobe falling edge land on the same clock edge, the load takes effect and the increment is dropped.
- R10: At each clock edge `rb_data` takes the byte of the count held before that edge, chosen by `rb_sel`: 2'b00 bits [7:0], 2'b01 bits [15:8], 2'b10 bits [18:16] zero-extended, 2'b11 gives 0.
- R11: Holding `wr_stb` high across many cycles loads once; holding `rd_stb` low across many cycles increments once per high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Data from the controller's port lines for address loads |
| wr_stb | input | 1 | Write strobe; a rising edge loads one address segment |
| seg_sel | input | 2 | Segment chosen by a write: 00 low, 01 middle, 10 upper, 11 none |
| rd_stb | input | 1 | Byte-read strobe; a falling edge advances the address |
| rb_sel | input | 2 | Byte of the count returned on `rb_data` |
| flash_addr | output | 19 | Address to the flash part |
| rb_data | output | 8 | Registered read-back byte of the count |

## Verification
Every cycle, the assertions check four things: an increment step including the wrap, the hold when no edge arrives, the cleared state after reset, and that a load leaves the other segments unchanged. They also check that the read-back byte follows the previous count. Other behaviour needs the bench's scenarios to show it. This covers the piecewise building of a full address across three writes and the rejection of the unused select code. It also covers edge-only action under strobes held for long periods and load-over-increment priority on a coinciding edge. For these the bench compares a behavioural model with every output on every clock, through directed walks and a long random phase.

// File: rtl/addr_walk_pkg.sv
package addr_walk_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] sel_t;

  // number of bus-wide segments needed to cover an address
  function automatic int seg_count(input int addr_w, input int bus_w);
    return (addr_w + bus_w - 1) / bus_w;
  endfunction

  // width of segment s (the top one may be narrower)
  function automatic int seg_width(input int addr_w, input int bus_w, input int s);
    int rem;
    rem = addr_w - s * bus_w;
    return (rem < bus_w) ? rem : bus_w;
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic hit
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = stb & ~stb_q;
    end else begin : g_fall
      assign hit = ~stb & stb_q;
    end
  endgenerate
endmodule

// File: rtl/walk_counter.sv
module walk_counter
  import addr_walk_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_data,
  input  sel_t              seg_sel,
  input  logic              load_hit,
  input  logic              step_hit,
  output logic [ADDR_W-1:0] count
);
  localparam int NSEG = seg_count(ADDR_W, BUS_W);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] load_val;

  genvar s;
  generate
    for (s = 0; s < NSEG; s++) begin : g_seg
      localparam int LO  = s * BUS_W;
      localparam int WID = seg_width(ADDR_W, BUS_W, s);
      assign load_val[LO +: WID] = (seg_sel == SEL_W'(s)) ? bus_data[WID-1:0]
                                                          : count[LO +: WID];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (load_hit) count <= load_val;
    else if (step_hit) count <= count + 1'b1;
  end

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (count == '0)); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (step_hit && !load_hit && count != TOP) |=> (count == $past(count) + 1'b1)); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step_hit && !load_hit && count == TOP) |=> (count == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!step_hit && !load_hit) |=> $stable(count)); // R2
  AST_LOW_LOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (load_hit && seg_sel == 2'b00) |=> $stable(count[ADDR_W-1:BUS_W])); // R3
  AST_NONE_LOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (load_hit && seg_sel == 2'b11) |=> $stable(count)); // R6
endmodule

// File: rtl/readback_mux.sv
module readback_mux
  import addr_walk_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] count,
  input  sel_t              rb_sel,
  output logic [BUS_W-1:0]  rb_data
);
  localparam int NSEG = seg_count(ADDR_W, BUS_W);

  logic [BUS_W-1:0] seg_bytes [NSEG];
  logic [BUS_W-1:0] pick;

  genvar s;
  generate
    for (s = 0; s < NSEG; s++) begin : g_seg
      localparam int LO  = s * BUS_W;
      localparam int WID = seg_width(ADDR_W, BUS_W, s);
      if (WID == BUS_W) begin : g_full
        assign seg_bytes[s] = count[LO +: WID];
      end else begin : g_part
        assign seg_bytes[s] = {{(BUS_W-WID){1'b0}}, count[LO +: WID]};
      end
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int i = 0; i < NSEG; i++)
      if (rb_sel == SEL_W'(i)) pick = seg_bytes[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rb_data <= '0;
    else     rb_data <= pick;
  end

  AST_RB_LOW: assert property (@(posedge clk) disable iff (rst)
    (rb_sel == 2'b00) |=> (rb_data == $past(count[BUS_W-1:0]))); // R10
  AST_RB_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rb_sel == 2'b11) |=> (rb_data == '0)); // R10
endmodule

// File: rtl/flash_addr_walker.sv
module flash_addr_walker
  import addr_walk_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              wr_stb,
  input  logic [1:0]        seg_sel,
  input  logic              rd_stb,
  input  logic [1:0]        rb_sel,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [BUS_W-1:0]  rb_data
);
  logic load_hit;
  logic step_hit;
  logic [ADDR_W-1:0] count;

  strobe_edge #(.RISING(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .stb(wr_stb), .hit(load_hit)
  );

  strobe_edge #(.RISING(1'b0)) u_rd_edge (
    .clk(clk), .rst(rst), .stb(rd_stb), .hit(step_hit)
  );

  walk_counter #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_cnt (
    .clk(clk), .rst(rst), .bus_data(bus_data), .seg_sel(seg_sel),
    .load_hit(load_hit), .step_hit(step_hit), .count(count)
  );

  readback_mux #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_rb (
    .clk(clk), .rst(rst), .count(count), .rb_sel(rb_sel), .rb_data(rb_data)
  );

  assign flash_addr = count;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (load_hit && step_hit && seg_sel == 2'b11) |=> $stable(flash_addr)); // R9
endmodule

// File: tb/tb_flash_addr_walker.sv
module tb_flash_addr_walker;
  localparam int AW = 19;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [BW-1:0] bus_data = '0;
  logic          wr_stb = 1'b0;
  logic [1:0]    seg_sel = 2'b11;
  logic          rd_stb = 1'b0;
  logic [1:0]    rb_sel = 2'b00;
  logic [AW-1:0] flash_addr;
  logic [BW-1:0] rb_data;

  always #5 clk = ~clk;

  flash_addr_walker #(.ADDR_W(AW), .BUS_W(BW)) dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .wr_stb(wr_stb),
    .seg_sel(seg_sel), .rd_stb(rd_stb), .rb_sel(rb_sel),
    .flash_addr(flash_addr), .rb_data(rb_data)
  );

  // behavioural reference
  int    m_cnt = 0;
  int    m_rb  = 0;
  bit    m_wrq = 0;
  bit    m_rdq = 0;
  int    vectors = 0;
  int    errors  = 0;
  string tag = "R1";
  bit    done = 0;

  always @(posedge clk) begin
    int old;
    old = m_cnt;
    if (rst) begin
      m_cnt = 0; m_rb = 0; m_wrq = 0; m_rdq = 0;
    end else begin
      case (rb_sel)
        2'd0: m_rb = old & 'hFF;
        2'd1: m_rb = (old >> 8) & 'hFF;
        2'd2: m_rb = (old >> 16) & 'h7;
        default: m_rb = 0;
      endcase
      if (wr_stb && !m_wrq) begin
        case (seg_sel)
          2'd0: m_cnt = (old & ~'hFF) | int'(bus_data);
          2'd1: m_cnt = (old & ~'hFF00) | (int'(bus_data) << 8);
          2'd2: m_cnt = (old & 'hFFFF) | ((int'(bus_data) & 7) << 16);
          default: m_cnt = old;
        endcase
      end else if (!rd_stb && m_rdq) begin
        m_cnt = (old + 1) & 'h7FFFF;
      end
      m_wrq = wr_stb;
      m_rdq = rd_stb;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(flash_addr) != m_cnt || int'(rb_data) != m_rb) begin
        errors++;
        $display("FAIL %s: addr=%05h rb=%02h expected addr=%05h rb=%02h",
                 tag, flash_addr, rb_data, m_cnt[AW-1:0], m_rb[BW-1:0]);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [7:0] d);
    seg_sel = s; bus_data = d; wr_stb = 1'b1; tick();
    wr_stb = 1'b0; tick();
  endtask

  task automatic rd_byte(int hold = 2);
    rd_stb = 1'b1; tick(hold);
    rd_stb = 1'b0; tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: run did not end, actual=%0d expected<=100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    tag = "R1"; tick(3);
    rst = 1'b0; tick();

    tag = "R3"; wr_seg(2'b00, 8'h45);
    tag = "R4"; wr_seg(2'b01, 8'h23);
    tag = "R5"; wr_seg(2'b10, 8'hF9);   // upper bits 001, data[7:3] ignored
    tag = "R6"; wr_seg(2'b11, 8'hAA);

    tag = "R10";
    for (int k = 0; k < 4; k++) begin rb_sel = 2'(k); tick(2); end

    tag = "R7";
    for (int k = 0; k < 6; k++) rd_byte(k + 1);

    tag = "R11";
    seg_sel = 2'b00; bus_data = 8'h10; wr_stb = 1'b1; tick(8);
    bus_data = 8'h77; tick(4); wr_stb = 1'b0; tick(8);
    rd_byte(1); tick(10);

    tag = "R8";
    wr_seg(2'b00, 8'hFE); wr_seg(2'b01, 8'hFF); wr_seg(2'b10, 8'h07);
    for (int k = 0; k < 3; k++) begin rb_sel = 2'b10; rd_byte(); end

    tag = "R9";
    rd_stb = 1'b1; tick(2);
    seg_sel = 2'b00; bus_data = 8'h3C; wr_stb = 1'b1; rd_stb = 1'b0; tick();
    wr_stb = 1'b0; tick(2);
    rd_stb = 1'b1; tick();
    seg_sel = 2'b11; wr_stb = 1'b1; rd_stb = 1'b0; tick();
    wr_stb = 1'b0; tick(2);

    tag = "R1";
    rst = 1'b1; tick(2); rst = 1'b0; tick(2);

    tag = "R2";
    for (int k = 0; k < 3000; k++) begin
      bus_data = 8'($urandom);
      seg_sel  = 2'($urandom);
      rb_sel   = 2'($urandom);
      wr_stb   = ($urandom % 5) == 0;
      rd_stb   = ($urandom % 2) == 0;
      if (($urandom % 500) == 0) rst = 1'b1; else rst = 1'b0;
      tick();
    end
    rst = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; tick(3);
    finish_run();
  end
endmodule